// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block times an external pulse signal. The signal passes through a synchronizer. On each edge the measurement mode selects, the block copies the elapsed number of count-enable ticks into a capture register, restarts the count and raises a one-cycle interrupt pulse. Software picks the edge pairing and the tick source through a byte-wide mode register. A control register starts and stops counting. The capture value is read a byte at a time over a simple register port.

Three edge pairings are available: falling edge to the next falling edge, rising edge to the next rising edge, and pulse width. In width mode every edge closes one interval and opens the next. The tick comes from one of several prescaler strobes supplied from outside the block. An external alternate-source enable can bypass the source field. A sticky overflow flag records that the counter wrapped. Software can only clear it, and only by writing the mode register.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset the mode register, control register and capture register all read 00h and `cap_irq` is low.
- R2: Mode register (address 0) layout: bits [1:0] operation mode, bits [3:2] measurement mode, bit 4 unimplemented (reads 0, writes ignored), bit 5 overflow flag (read-only), bits [7:6] count source. The writable fields read back what was written.
- R3: Counting runs only while the start bit (address 1, bit 0) is 1 and the operation mode is 10b. Otherwise no capture, no interrupt and no overflow takes place, whatever the input does.
- R4: Measurement mode 00b captures on each falling edge of the input, measuring falling edge to falling edge.
- R5: Measurement mode 01b captures on each rising edge, measuring rising edge to rising edge.
- R6: Measurement mode 10b captures on every edge, so it alternately measures the high and the low phase.
- R7: Measurement mode 11b is reserved. It performs no capture and raises no interrupt.
- R8: The first qualifying edge after counting starts only restarts the count. It raises no interrupt and leaves the capture register unchanged.
- R9: The capture value is the number of selected ticks from the cycle of one qualifying edge up to the cycle before the next one. `cap_irq` is high for exactly one cycle, in the third cycle after the input change, and the capture register updates in that same cycle.
- R10: Count source codes: 00b gives `ce_div1`, or `ce_div2` when `div2_sel` is 1; 01b gives `ce_div8`; 10b gives `ce_div32`; 11b gives `ce_sub32`.
- R11: While `alt_src_en` is 1 the source field is ignored and `ce_alt` is the tick.
- R12: A counter wrap from all ones to zero sets the overflow flag. The flag stays set, and the wrapped count is still captured modulo 2^16.
- R13: Only a write to the mode register clears the overflow flag, whatever value is written to bit 5. Control-register writes leave the flag unchanged. If a wrap occurs in the same cycle as the write, the flag is set.
- R14: The capture register reads at address 2 (bits 7:0) and address 3 (bits 15:8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pulse_in | input | 1 | Measured pulse, asynchronous |
| div2_sel | input | 1 | Use the divide-by-2 strobe for source code 00b |
| alt_src_en | input | 1 | Use ce_alt instead of the source field |
| ce_div1 | input | 1 | Tick strobe, base clock |
| ce_div2 | input | 1 | Tick strobe, base clock / 2 |
| ce_div8 | input | 1 | Tick strobe, / 8 |
| ce_div32 | input | 1 | Tick strobe, / 32 |
| ce_sub32 | input | 1 | Tick strobe, sub-clock / 32 |
| ce_alt | input | 1 | Alternate tick strobe |
| cap_irq | output | 1 | One-cycle capture-done pulse |

## Verification
An input change passes through two synchronizer flops and one edge register. The interrupt and the new capture value therefore appear three clock edges after the change, and the bench checks for the pulse at each of those edges in turn. Tick strobes run free with fixed periods, and every phase length is a multiple of the selected period, so each interval holds an exact number of ticks. Capture values and interrupt counts are read only after the last edge has had time to register. Register reads are combinational and are sampled between edges. The overflow flag is read after the wrap and again after control and mode writes.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   typedef enum logic [1:0] {
      MEAS_FALL  = 2'b00,
      MEAS_RISE  = 2'b01,
      MEAS_WIDTH = 2'b10,
      MEAS_RSVD  = 2'b11
   } meas_e;

   typedef enum logic [1:0] {
      SRC_BASE  = 2'b00,
      SRC_DIV8  = 2'b01,
      SRC_DIV32 = 2'b10,
      SRC_SUB32 = 2'b11
   } src_e;

   localparam logic [1:0] OPMODE_MEAS = 2'b10;

   localparam int MODE_ADDR = 0;
   localparam int CTRL_ADDR = 1;
   localparam int CAP_ADDR0 = 2;

endpackage

// File: rtl/pmt_sync_edge.sv
module pmt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   localparam int MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pmt_sync_edge: STAGES must be at least 2");
   end

   logic [MSB:0] sh;
   logic         prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[MSB-1:0], din};
         prev <= sh[MSB];
      end
   end

   assign rise = sh[MSB] & ~prev;
   assign fall = ~sh[MSB] & prev;
endmodule

// File: rtl/pmt_src_sel.sv
module pmt_src_sel
   import pmt_pkg::*;
(
   input  src_e src,
   input  logic div2_sel,
   input  logic alt_src_en,
   input  logic ce_div1,
   input  logic ce_div2,
   input  logic ce_div8,
   input  logic ce_div32,
   input  logic ce_sub32,
   input  logic ce_alt,
   output logic tick
);
   logic field_tick;

   always_comb begin
      unique case (src)
         SRC_BASE:  field_tick = div2_sel ? ce_div2 : ce_div1;
         SRC_DIV8:  field_tick = ce_div8;
         SRC_DIV32: field_tick = ce_div32;
         SRC_SUB32: field_tick = ce_sub32;
         default:   field_tick = 1'b0;
      endcase
   end

   assign tick = alt_src_en ? ce_alt : field_tick;
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             edge_hit,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             irq,
   output logic             wrap
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         capture <= '0;
         irq     <= 1'b0;
         armed   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!run) begin
            armed <= 1'b0;
         end else if (edge_hit) begin
            if (armed) begin
               capture <= count;
               irq     <= 1'b1;
            end
            armed <= 1'b1;
            count <= tick ? CNT_W'(1) : '0;
         end else if (tick) begin
            count <= count + CNT_W'(1);
         end
      end
   end

   assign wrap = run & tick & ~edge_hit & (count == '1);
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
   import pmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              wrap,
   input  logic [CNT_W-1:0]  capture,
   output logic [7:0]        rdata,
   output logic [1:0]        opmode,
   output meas_e             meas,
   output src_e              src,
   output logic              start,
   output logic              ovf,
   output logic              mode_wr
);
   localparam int CAP_BYTES = CNT_W / 8;

   logic ctrl_wr;
   logic unused_wbits;
   logic [7:0] cap_byte [CAP_BYTES];

   assign mode_wr      = wr_en && (addr == ADDR_W'(MODE_ADDR));
   assign ctrl_wr      = wr_en && (addr == ADDR_W'(CTRL_ADDR));
   assign unused_wbits = ^wdata[5:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opmode <= 2'b00;
         meas   <= MEAS_FALL;
         src    <= SRC_BASE;
         start  <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         if (mode_wr) begin
            opmode <= wdata[1:0];
            meas   <= meas_e'(wdata[3:2]);
            src    <= src_e'(wdata[7:6]);
         end
         if (ctrl_wr) start <= wdata[0];
         if (wrap)         ovf <= 1'b1;
         else if (mode_wr) ovf <= 1'b0;
      end
   end

   for (genvar b = 0; b < CAP_BYTES; b++) begin : g_cap_bytes
      assign cap_byte[b] = capture[8*b +: 8];
   end

   always_comb begin
      rdata = 8'h00;
      if (addr == ADDR_W'(MODE_ADDR)) begin
         rdata = {src, ovf, 1'b0, meas, opmode};
      end else if (addr == ADDR_W'(CTRL_ADDR)) begin
         rdata = {7'b0, start};
      end else begin
         for (int i = 0; i < CAP_BYTES; i++) begin
            if (addr == ADDR_W'(CAP_ADDR0 + i)) rdata = cap_byte[i];
         end
      end
   end
endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
   import pmt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CAP_BYTES  = CNT_W / 8,
   localparam int NUM_REGS   = CAP_ADDR0 + CAP_BYTES,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              pulse_in,
   input  logic              div2_sel,
   input  logic              alt_src_en,
   input  logic              ce_div1,
   input  logic              ce_div2,
   input  logic              ce_div8,
   input  logic              ce_div32,
   input  logic              ce_sub32,
   input  logic              ce_alt,
   output logic              cap_irq
);
   if ((CNT_W % 8) != 0 || CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("pulse_meas_timer: CNT_W must be 8, 16, 24 or 32");
   end

   logic [1:0]       opmode;
   meas_e            meas;
   src_e             src;
   logic             start;
   logic             ovf;
   logic             mode_wr;
   logic             run;
   logic             tick;
   logic             rise;
   logic             fall;
   logic             edge_hit;
   logic             wrap;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] capture;

   pmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .wrap(wrap), .capture(capture), .rdata(reg_rdata),
      .opmode(opmode), .meas(meas), .src(src), .start(start), .ovf(ovf),
      .mode_wr(mode_wr)
   );

   pmt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pulse_in), .rise(rise), .fall(fall)
   );

   pmt_src_sel u_src (
      .src(src), .div2_sel(div2_sel), .alt_src_en(alt_src_en),
      .ce_div1(ce_div1), .ce_div2(ce_div2), .ce_div8(ce_div8),
      .ce_div32(ce_div32), .ce_sub32(ce_sub32), .ce_alt(ce_alt), .tick(tick)
   );

   assign run = start && (opmode == OPMODE_MEAS);

   always_comb begin
      unique case (meas)
         MEAS_FALL:  edge_hit = fall;
         MEAS_RISE:  edge_hit = rise;
         MEAS_WIDTH: edge_hit = rise | fall;
         default:    edge_hit = 1'b0;
      endcase
   end

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .edge_hit(edge_hit),
      .count(count), .capture(capture), .irq(cap_irq), .wrap(wrap)
   );
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              edge_hit,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  capture,
   input logic              cap_irq,
   input logic              wrap,
   input logic              ovf,
   input logic              mode_wr,
   input logic [1:0]        meas,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata
);
   // R3: stopped counter holds and raises nothing
   a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(count) && !cap_irq));

   // R7: reserved measurement mode never captures
   a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (meas == 2'b11) |=> !cap_irq);

   // R9: interrupt comes with the count held in the edge cycle
   a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |-> (capture == $past(count)));

   // R9: an interrupt follows only a qualifying edge
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq |-> $past(edge_hit && run));

   // R12: flag rises only on a wrap
   a_r12_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(wrap));

   // R12: flag is sticky until a mode write
   a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !mode_wr) |=> ovf);

   // R13: mode write clears the flag unless a wrap coincides
   a_r13_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !wrap) |=> !ovf);

   // R2: unimplemented bit reads zero
   a_r2_rsvd_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> (reg_rdata[4] == 1'b0));
endmodule

bind pulse_meas_timer pmt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .edge_hit(edge_hit), .count(count),
   .capture(capture), .cap_irq(cap_irq), .wrap(wrap), .ovf(ovf),
   .mode_wr(mode_wr), .meas(meas), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/pulse_meas_timer_tb.sv
`timescale 1ns/1ps
module pulse_meas_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       pulse_in = 1'b1;
   logic       div2_sel = 1'b0;
   logic       alt_src_en = 1'b0;
   logic       ce_div1 = 1'b0, ce_div2 = 1'b0, ce_div8 = 1'b0;
   logic       ce_div32 = 1'b0, ce_sub32 = 1'b0, ce_alt = 1'b0;
   logic       cap_irq;

   int checks = 0;
   int fails  = 0;
   int irq_cnt = 0;
   int tc = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   pulse_meas_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
      .div2_sel(div2_sel), .alt_src_en(alt_src_en), .ce_div1(ce_div1),
      .ce_div2(ce_div2), .ce_div8(ce_div8), .ce_div32(ce_div32),
      .ce_sub32(ce_sub32), .ce_alt(ce_alt), .cap_irq(cap_irq)
   );

   // free-running tick strobes with fixed periods 1, 2, 8, 32, 64, 4
   always @(negedge clk) begin
      tc <= tc + 1;
      ce_div1  <= 1'b1;
      ce_div2  <= (tc % 2) == 0;
      ce_div8  <= (tc % 8) == 0;
      ce_div32 <= (tc % 32) == 0;
      ce_sub32 <= (tc % 64) == 0;
      ce_alt   <= (tc % 4) == 0;
   end

   always @(negedge clk) if (rst_n && cap_irq) irq_cnt <= irq_cnt + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; #0.5; d = reg_rdata;
   endtask

   task automatic rd_cap(output int v);
      logic [7:0] lo, hi;
      rd(2'd2, lo); rd(2'd3, hi);
      v = {hi, lo};
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // {meas, src, div2, alt, hi, lo, expected irqs, expected capture}
   typedef struct packed {
      logic [1:0]  meas;
      logic [1:0]  src;
      logic        d2;
      logic        alt;
      logic [7:0]  hi;
      logic [7:0]  lo;
      logic [3:0]  exp_irq;
      logic [15:0] exp_cap;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 2'b00, 1'b0, 1'b0, 8'd20,  8'd30,  4'd2, 16'd50}, // R4 R10
      '{2'b01, 2'b00, 1'b1, 1'b0, 8'd20,  8'd12,  4'd1, 16'd16}, // R5 R10
      '{2'b10, 2'b01, 1'b0, 1'b0, 8'd40,  8'd24,  4'd4, 16'd5},  // R6 R10
      '{2'b11, 2'b00, 1'b0, 1'b0, 8'd20,  8'd20,  4'd0, 16'd5},  // R7
      '{2'b00, 2'b10, 1'b0, 1'b0, 8'd64,  8'd128, 4'd2, 16'd6},  // R4 R10
      '{2'b10, 2'b11, 1'b0, 1'b0, 8'd128, 8'd64,  4'd4, 16'd2},  // R6 R10
      '{2'b00, 2'b11, 1'b0, 1'b1, 8'd12,  8'd20,  4'd2, 16'd8}   // R11
   };

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int cap, snap;
      wait_n(3);
      // R1: reset state
      check("R1 irq", int'(cap_irq), 0);
      rd(2'd0, d); check("R1 mode", d, 0);
      rd(2'd1, d); check("R1 ctrl", d, 0);
      rd(2'd2, d); check("R1 cap lo", d, 0);
      rd(2'd3, d); check("R1 cap hi", d, 0);
      rst_n = 1'b1;
      wait_n(4);

      // R2: writable fields read back, bits 4 and 5 cannot be set
      wr(2'd0, 8'hD6);
      rd(2'd0, d); check("R2 mode readback", d, 8'hC6);

      // vector table: R4 R5 R6 R7 R10 R11 R14
      for (int v = 0; v < NV; v++) begin
         wr(2'd1, 8'h00);
         wr(2'd0, {VECS[v].src, 2'b00, VECS[v].meas, 2'b10});
         div2_sel = VECS[v].d2; alt_src_en = VECS[v].alt;
         pulse_in = 1'b1; wait_n(6);
         irq_cnt = 0;
         wr(2'd1, 8'h01); wait_n(4);
         pulse_in = 1'b0; wait_n(VECS[v].lo);
         pulse_in = 1'b1; wait_n(VECS[v].hi);
         pulse_in = 1'b0; wait_n(VECS[v].lo);
         pulse_in = 1'b1; wait_n(VECS[v].hi);
         pulse_in = 1'b0; wait_n(6);
         check($sformatf("R9 vec%0d irq count", v), irq_cnt, VECS[v].exp_irq);
         rd_cap(cap);
         check($sformatf("R14 vec%0d capture", v), cap, VECS[v].exp_cap);
      end
      wr(2'd1, 8'h00);
      alt_src_en = 1'b0; div2_sel = 1'b0;

      // R3: operation mode other than 10b, and start cleared
      irq_cnt = 0;
      wr(2'd0, 8'h00); wr(2'd1, 8'h01); wait_n(4);
      for (int k = 0; k < 4; k++) begin pulse_in = ~pulse_in; wait_n(8); end
      wr(2'd1, 8'h00); wr(2'd0, 8'h0A); wait_n(4);
      for (int k = 0; k < 4; k++) begin pulse_in = ~pulse_in; wait_n(8); end
      check("R3 no irq while idle", irq_cnt, 0);
      rd_cap(cap); check("R3 capture unchanged", cap, 8);

      // R8 and R9: width mode, arm then exact timing
      pulse_in = 1'b1; wait_n(6);
      irq_cnt = 0;
      wr(2'd1, 8'h01); wait_n(4);
      pulse_in = 1'b0; wait_n(10);
      check("R8 first edge no irq", irq_cnt, 0);
      pulse_in = 1'b1;
      wait_n(2); check("R9 irq low at 2", int'(cap_irq), 0);
      wait_n(1); check("R9 irq high at 3", int'(cap_irq), 1);
      wait_n(1); check("R9 irq low at 4", int'(cap_irq), 0);
      rd_cap(cap); check("R9 capture 10", cap, 10);

      // R12 and R13: overflow
      wr(2'd1, 8'h00); wr(2'd0, 8'h02);
      pulse_in = 1'b1; wait_n(6);
      wr(2'd1, 8'h01); wait_n(4);
      pulse_in = 1'b0; wait_n(20);
      rd(2'd0, d); check("R12 no overflow yet", d, 8'h02);
      pulse_in = 1'b1; wait_n(69980);
      pulse_in = 1'b0; wait_n(5);
      rd(2'd0, d); check("R12 overflow set", d, 8'h22);
      rd_cap(cap); check("R12 wrapped capture", cap, 70000 - 65536);
      wr(2'd1, 8'h00);
      rd(2'd0, d); check("R13 ctrl write keeps flag", d, 8'h22);
      wr(2'd0, 8'h22);
      rd(2'd0, d); check("R13 mode write clears flag", d, 8'h02);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule